// File: doc/BRIEF.md
# Endpoint Sticky Interrupt Aggregator

This block collects event pulses from five device endpoints into one interrupt line. Each endpoint has five causes: setup packet received, data received into bank 0, data received into bank 1, transmission complete and stall handshake sent. A pulse on any cause sets a latched cause bit. That bit holds until firmware clears it by writing a 1 to it through the clear port, which addresses one endpoint's status word at a time.

An endpoint's pending bit is the OR of its five latched causes. It therefore stays high until every cause of that endpoint has been cleared. A shared enable mask is changed through two write strobes, one that sets bits and one that clears them. The interrupt output is high whenever an enabled endpoint has a pending bit. Firmware reads the pending word, the mask word and the cause word of one selected endpoint through a combinational read port.

Top module: `ep_irq_agg`

## Requirements
- R1: After reset every cause bit, every pending bit and every mask bit is 0, and `irq` is 0.
- R2: A 1 on `src_pulse[e*5+c]` at a clock edge sets cause bit c of endpoint e. The cause order is 0 = setup received, 1 = bank 0 received, 2 = bank 1 received, 3 = transmit complete, 4 = stall sent. The bit is visible on the next cycle.
- R3: `pend[e]` is the OR of the five cause bits of endpoint e.
- R4: A cause bit stays set until a clear write names its endpoint with a 1 in that bit position. Clearing only some causes leaves the pending bit high. A clear write with zero bits changes nothing.
- R5: A clear write changes only the endpoint selected by `clr_ep`. A `clr_ep` value of 5 or more is ignored.
- R6: When a source pulse and a clear write hit the same cause bit in the same cycle, the bit ends up set.
- R7: `en_we` sets the mask bits that are 1 in `en_data`, and `dis_we` clears the mask bits that are 1 in `dis_data`. Zero bits have no effect. When both strobes name the same bit in one cycle, the bit ends up cleared.
- R8: `irq` is high exactly when some endpoint has both its pending bit and its mask bit set.
- R9: `rd_cause` returns the cause word of endpoint `rd_ep`, and returns 0 when `rd_ep` is 5 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 25 | Cause pulses, endpoint e cause c at bit e*5+c |
| clr_we | input | 1 | Clear-write strobe |
| clr_ep | input | 3 | Endpoint addressed by the clear write |
| clr_bits | input | 5 | Write-1-to-clear cause bits |
| en_we | input | 1 | Mask set strobe |
| en_data | input | 5 | Mask bits to set |
| dis_we | input | 1 | Mask clear strobe |
| dis_data | input | 5 | Mask bits to clear |
| rd_ep | input | 3 | Endpoint whose cause word is read |
| rd_cause | output | 5 | Cause word of `rd_ep` |
| pend | output | 5 | Pending bit per endpoint |
| mask | output | 5 | Current enable mask |
| irq | output | 1 | Interrupt line |

## Verification
Every cause of every endpoint is pulsed on its own, with all other sources idle. This shows that each source bit lands in the right endpoint and the right position and in no other. Causes are then stacked on one endpoint and removed one at a time, which separates a pending bit computed as an OR from one that drops on the first clear. Clears aimed at a neighbouring endpoint or at an unused address show whether the address decode is exact. Same-cycle collisions of a pulse with a clear, and of an enable with a disable, fix the documented winner. Mask patterns with and without pending endpoints tell the gating apart from a plain OR of the pending bits.

// File: rtl/ep_irq_agg.sv
module ep_irq_agg #(
  parameter int NUM_EP    = 5,
  parameter int NUM_CAUSE = 5,
  localparam int EPW      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int NSRC     = NUM_EP * NUM_CAUSE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_pulse,
  input  logic                 clr_we,
  input  logic [EPW-1:0]       clr_ep,
  input  logic [NUM_CAUSE-1:0] clr_bits,
  input  logic                 en_we,
  input  logic [NUM_EP-1:0]    en_data,
  input  logic                 dis_we,
  input  logic [NUM_EP-1:0]    dis_data,
  input  logic [EPW-1:0]       rd_ep,
  output logic [NUM_CAUSE-1:0] rd_cause,
  output logic [NUM_EP-1:0]    pend,
  output logic [NUM_EP-1:0]    mask,
  output logic                 irq
);

  logic [NUM_CAUSE-1:0] cause_q [NUM_EP];
  logic [NUM_EP-1:0]    mask_q;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic                 hit;
    logic [NUM_CAUSE-1:0] wipe;

    assign hit  = clr_we && (clr_ep == EPW'(e));
    assign wipe = hit ? clr_bits : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) cause_q[e] <= '0;
      else        cause_q[e] <= (cause_q[e] & ~wipe) | src_pulse[e*NUM_CAUSE +: NUM_CAUSE];
    end

    assign pend[e] = |cause_q[e];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= (mask_q | (en_we ? en_data : '0)) & ~(dis_we ? dis_data : '0);
  end

  always_comb begin
    rd_cause = '0;
    for (int e = 0; e < NUM_EP; e++)
      if (rd_ep == EPW'(e)) rd_cause = cause_q[e];
  end

  assign mask = mask_q;
  assign irq  = |(pend & mask_q);

endmodule

// File: rtl/ep_irq_agg_chk.sv
module ep_irq_agg_chk #(
  parameter int NUM_EP    = 5,
  parameter int NUM_CAUSE = 5,
  localparam int EPW      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int NSRC     = NUM_EP * NUM_CAUSE
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   src_pulse,
  input logic              clr_we,
  input logic              en_we,
  input logic [NUM_EP-1:0] en_data,
  input logic              dis_we,
  input logic [NUM_EP-1:0] dis_data,
  input logic [NUM_EP-1:0] pend,
  input logic [NUM_EP-1:0] mask,
  input logic              irq
);

  for (genvar e = 0; e < NUM_EP; e++) begin : g_set
    // R2
    src_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_pulse[e*NUM_CAUSE +: NUM_CAUSE]) |=> pend[e]);
  end

  // R4
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((pend & $past(pend)) == $past(pend)));

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_we && !dis_we) |=> $stable(mask));

  // R7
  mask_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_we |=> ((mask & $past(dis_data)) == '0));

  // R7
  mask_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && !dis_we) |=> ((mask & $past(en_data)) == $past(en_data)));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend == '0) || (mask == '0)) |-> !irq);

  // R8
  irq_needs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend & mask) != '0));

endmodule

bind ep_irq_agg ep_irq_agg_chk #(.NUM_EP(NUM_EP), .NUM_CAUSE(NUM_CAUSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .clr_we(clr_we),
  .en_we(en_we), .en_data(en_data), .dis_we(dis_we), .dis_data(dis_data),
  .pend(pend), .mask(mask), .irq(irq)
);

// File: tb/ep_irq_agg_bench.sv
module ep_irq_agg_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [24:0] src_pulse = '0;
  logic        clr_we = 0;
  logic [2:0]  clr_ep = '0;
  logic [4:0]  clr_bits = '0;
  logic        en_we = 0;
  logic [4:0]  en_data = '0;
  logic        dis_we = 0;
  logic [4:0]  dis_data = '0;
  logic [2:0]  rd_ep = '0;
  logic [4:0]  rd_cause, pend, mask;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ep_irq_agg u_ep_irq_agg (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    src_pulse = '0; clr_we = 0; clr_bits = '0; clr_ep = '0;
    en_we = 0; en_data = '0; dis_we = 0; dis_data = '0;
  endtask

  // apply current inputs for one edge, then return them to idle at the next negedge
  task automatic tick();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic pulse(int e, int c);
    src_pulse = '0; src_pulse[e*5+c] = 1'b1; tick();
  endtask

  task automatic clear(int e, logic [4:0] b);
    clr_we = 1; clr_ep = 3'(e); clr_bits = b; tick();
  endtask

  task automatic read_ep(int e, output int v);
    rd_ep = 3'(e); #1 v = int'(rd_cause);
  endtask

  task automatic t_reset();
    int v;
    chk("R1 pend", int'(pend), 0);
    chk("R1 mask", int'(mask), 0);
    chk("R1 irq", int'(irq), 0);
    for (int e = 0; e < 5; e++) begin read_ep(e, v); chk("R1 cause", v, 0); end
  endtask

  task automatic t_single();
    int v;
    for (int e = 0; e < 5; e++)
      for (int c = 0; c < 5; c++) begin
        pulse(e, c);
        read_ep(e, v);
        chk("R2 cause bit", v, 1 << c);
        chk("R3 pend", int'(pend), 1 << e);
        chk("R8 masked irq", int'(irq), 0);
        clear(e, 5'h1f);
        chk("R4 cleared", int'(pend), 0);
      end
  endtask

  task automatic t_partial();
    int v;
    pulse(2, 0); pulse(2, 4);
    read_ep(2, v); chk("R2 stacked", v, 5'h11);
    clear(2, 5'h00);
    read_ep(2, v); chk("R4 zero clear", v, 5'h11);
    clear(2, 5'h01);
    read_ep(2, v); chk("R4 partial", v, 5'h10);
    chk("R3 still pending", int'(pend), 5'h04);
    clear(2, 5'h10);
    chk("R4 all cleared", int'(pend), 0);
  endtask

  task automatic t_target();
    int v;
    pulse(1, 3); pulse(3, 2);
    clear(7, 5'h1f);
    chk("R5 bad address", int'(pend), 5'h0a);
    clear(1, 5'h1f);
    chk("R5 neighbour kept", int'(pend), 5'h08);
    read_ep(3, v); chk("R5 neighbour cause", v, 5'h04);
    read_ep(6, v); chk("R9 out of range read", v, 0);
    clear(3, 5'h1f);
  endtask

  task automatic t_collide();
    int v;
    pulse(0, 1);
    src_pulse[1] = 1; clr_we = 1; clr_ep = 0; clr_bits = 5'h02; tick();
    read_ep(0, v); chk("R6 set wins", v, 5'h02);
    src_pulse[2] = 1; clr_we = 1; clr_ep = 0; clr_bits = 5'h02; tick();
    read_ep(0, v); chk("R6 other bit", v, 5'h04);
    clear(0, 5'h1f);
  endtask

  task automatic t_mask();
    en_we = 1; en_data = 5'b00101; tick();
    chk("R7 enable", int'(mask), 5'b00101);
    en_we = 1; en_data = 0; dis_we = 1; dis_data = 0; tick();
    chk("R7 zero writes", int'(mask), 5'b00101);
    dis_we = 1; dis_data = 5'b00001; tick();
    chk("R7 disable", int'(mask), 5'b00100);
    en_we = 1; en_data = 5'b01000; dis_we = 1; dis_data = 5'b01000; tick();
    chk("R7 disable wins", int'(mask), 5'b00100);
  endtask

  task automatic t_irq();
    pulse(4, 0);
    chk("R8 unmasked ep idle", int'(irq), 0);
    pulse(2, 3);
    chk("R8 irq raised", int'(irq), 1);
    dis_we = 1; dis_data = 5'b00100; tick();
    chk("R8 irq masked", int'(irq), 0);
    en_we = 1; en_data = 5'b10000; tick();
    chk("R8 irq other ep", int'(irq), 1);
    clear(4, 5'h01);
    chk("R8 irq after clear", int'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_partial();
    t_target();
    t_collide();
    t_mask();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule